// File: doc/BRIEF.md
# Parity-Checked Registered Address Buffer

This block is a clocked register for a command/address word. The default word is 14 bits. The word is loaded from the input pins whenever at least one of two active-low select inputs is low. It is then driven on registered outputs.

Behind the data register sits a two-stage parity pipeline. The parity bit for a word arrives one clock after the word itself. The block folds that bit together with the captured data bits and presents the result on a partial-parity output, so that a companion device can finish a wider check. If the combined XOR is 1, the block drives an active-low error flag.

The error flag is produced by a small state machine with two states. `ST_CLEAR` means the flag is high. `ST_STRETCH` means the flag is held low while a down-counter runs. The machine has three transitions:
- "hit" moves `ST_CLEAR` to `ST_STRETCH`.
- "rehit" stays in `ST_STRETCH` and reloads the counter.
- "expire" returns `ST_STRETCH` to `ST_CLEAR` when the counter has reached zero and no new error is seen.

An asynchronous active-low reset clears the data outputs, the partial-parity output and the whole pipeline, and raises the flag.

Top module: `parity_addr_buffer`

## Requirements
- R1: On a rising clock edge where `sel0_n` or `sel1_n` (or both) is 0, `addr_q` takes the value of `addr_i` sampled at that edge.
- R2: On a rising clock edge where both selects are 1, `addr_q` keeps its value. The word on `addr_i` at that edge never reaches the parity pipeline: neither `ppar_o` nor `err_n` responds to it, whatever `par_i` carries on the next edge.
- R3: For a word captured at edge n, `par_i` is sampled at edge n+1. If the XOR of the captured word and that parity bit is 1, `err_n` is 0 after edge n+2.
- R4: Once driven low, `err_n` stays 0 for exactly HOLD_CYC clock cycles (default 2, at least 2). It then returns to 1 if no further error is detected.
- R5: An error detected while `err_n` is already 0 restarts the hold count, so the flag stays low for HOLD_CYC cycles counted from that later edge.
- R6: For a word captured at edge n, `ppar_o` after edge n+2 equals the XOR of the captured word and `par_i` sampled at edge n+1. `ppar_o` holds its value at edges that have no such word.
- R7: While `rst_n` is 0, `addr_q` = 0, `ppar_o` = 0 and `err_n` = 1. These values take effect at once, without a clock edge.
- R8: After `rst_n` rises, the pipeline starts empty. `err_n` stays 1 and `ppar_o` stays 0 for the first two edges, and for as long as the inputs are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel0_n | input | 1 | First select, active low |
| sel1_n | input | 1 | Second select, active low |
| addr_i | input | DATA_W | Command/address word in |
| par_i | input | 1 | Parity bit, one clock after its word |
| addr_q | output | DATA_W | Registered word |
| ppar_o | output | 1 | Partial parity for the companion device |
| err_n | output | 1 | Parity error flag, active low, stretched |

## Verification
The bench builds the block with its defaults: a 14-bit word and a hold of two cycles. With a hold this short, the "expire" transition and the "rehit" restart both fall within a dozen vector rows, so their edge positions can be checked exactly. A gated word followed by a parity bit that would flag an error shows that unselected cycles leave the pipeline untouched. Each select is exercised on its own. Reset is applied mid-stretch to show the asynchronous clear, and is then released with quiet inputs to show the clean start.

// File: rtl/pab_pkg.sv
package pab_pkg;

    // Error flag machine states
    typedef enum logic [0:0] {
        ST_CLEAR   = 1'b0,   // flag high, no error pending
        ST_STRETCH = 1'b1    // flag low, hold counter running
    } err_state_e;

    localparam int unsigned DEF_DATA_W   = 14;
    localparam int unsigned DEF_HOLD_CYC = 2;

endpackage

// File: rtl/pab_capture.sv
module pab_capture #(
    parameter int unsigned DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/pab_parity_pipe.sv
module pab_parity_pipe #(
    parameter int unsigned DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              par_in,
    output logic              ppo,
    output logic              hit
);

    // XOR fold of the data word, built as a chain
    logic [DATA_W:0] fold;
    assign fold[0] = 1'b0;
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_fold
        assign fold[gi+1] = fold[gi] ^ din[gi];
    end

    // Stage 1: word parity, marked valid only for captured words
    logic s1_vld, s1_par;
    // Stage 2: word parity merged with the late parity bit
    logic s2_vld, s2_par;
    // Stage 3: partial parity output register
    logic ppo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_par <= 1'b0;
        end else begin
            s1_vld <= load;
            if (load) begin
                s1_par <= fold[DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            s2_par <= 1'b0;
        end else begin
            s2_vld <= s1_vld;
            if (s1_vld) begin
                s2_par <= s1_par ^ par_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ppo_q <= 1'b0;
        end else if (s2_vld) begin
            ppo_q <= s2_par;
        end
    end

    assign ppo = ppo_q;
    assign hit = s2_vld & s2_par;

endmodule

// File: rtl/pab_err_fsm.sv
module pab_err_fsm
    import pab_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic err_n
);

    localparam int unsigned CNT_W  = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYC - 1);

    err_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions: hit, rehit, expire
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (hit) begin
                    state_d = ST_STRETCH;
                    cnt_d   = RELOAD;
                end
            end
            ST_STRETCH: begin
                if (hit) begin
                    cnt_d = RELOAD;
                end else if (cnt_q == '0) begin
                    state_d = ST_CLEAR;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_CLEAR;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        err_n = (state_q != ST_STRETCH);
    end

endmodule

// File: rtl/parity_addr_buffer.sv
module parity_addr_buffer
    import pab_pkg::*;
#(
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned HOLD_CYC = DEF_HOLD_CYC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel0_n,
    input  logic              sel1_n,
    input  logic [DATA_W-1:0] addr_i,
    input  logic              par_i,
    output logic [DATA_W-1:0] addr_q,
    output logic              ppar_o,
    output logic              err_n
);

    logic load;
    logic hit;

    assign load = ~(sel0_n & sel1_n);

    pab_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (addr_i),
        .q     (addr_q)
    );

    pab_parity_pipe #(.DATA_W(DATA_W)) u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .din    (addr_i),
        .par_in (par_i),
        .ppo    (ppar_o),
        .hit    (hit)
    );

    pab_err_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .err_n (err_n)
    );

endmodule

// File: rtl/pab_checker.sv
module pab_checker #(
    parameter int unsigned DATA_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel0_n,
    input logic              sel1_n,
    input logic [DATA_W-1:0] addr_i,
    input logic              par_i,
    input logic [DATA_W-1:0] addr_q,
    input logic              ppar_o,
    input logic              err_n
);

    logic       sel;
    logic       wpar;
    logic [1:0] since;

    assign sel  = ~(sel0_n & sel1_n);
    assign wpar = ^addr_i;

    // Edges seen since reset release, saturating at 3
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= 2'd0;
        end else if (since != 2'd3) begin
            since <= since + 2'd1;
        end
    end

    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> addr_q == $past(addr_i));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(addr_q));

    a_r3_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 2'd3 && $past(sel, 3) && ($past(wpar, 3) ^ $past(par_i, 2)))
        |-> !err_n);

    a_r4_min_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n);

    a_r6_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 2'd3 && $past(sel, 3))
        |-> ppar_o == ($past(wpar, 3) ^ $past(par_i, 2)));

    a_r7_reset_vals: assert property (@(posedge clk)
        !rst_n |-> (addr_q == '0 && !ppar_o && err_n));

    a_r8_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 2'd3) |-> (err_n && !ppar_o));

endmodule

bind parity_addr_buffer pab_checker #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel0_n (sel0_n),
    .sel1_n (sel1_n),
    .addr_i (addr_i),
    .par_i  (par_i),
    .addr_q (addr_q),
    .ppar_o (ppar_o),
    .err_n  (err_n)
);

// File: tb/tb_parity_addr_buffer.sv
module tb_parity_addr_buffer;

    localparam int W = 14;
    localparam int NV = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel0_n = 1'b1;
    logic         sel1_n = 1'b1;
    logic [W-1:0] addr_i = '0;
    logic         par_i = 1'b0;
    logic [W-1:0] addr_q;
    logic         ppar_o;
    logic         err_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    parity_addr_buffer #(.DATA_W(W), .HOLD_CYC(2)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel0_n (sel0_n),
        .sel1_n (sel1_n),
        .addr_i (addr_i),
        .par_i  (par_i),
        .addr_q (addr_q),
        .ppar_o (ppar_o),
        .err_n  (err_n)
    );

    // Row: {sel0_n, sel1_n, addr_i, par_i, exp addr_q, exp ppar_o, exp err_n}
    // par_i on a row belongs to the word of the row before.
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 1'b1, 14'h0001, 1'b0, 14'h0001, 1'b0, 1'b1}, // R1 sel0 only
        {1'b0, 1'b1, 14'h0003, 1'b1, 14'h0003, 1'b0, 1'b1}, // good parity
        {1'b1, 1'b0, 14'h3FFF, 1'b0, 14'h3FFF, 1'b0, 1'b1}, // R1 sel1 only
        {1'b0, 1'b0, 14'h1555, 1'b1, 14'h1555, 1'b0, 1'b1}, // bad parity on 3FFF
        {1'b1, 1'b1, 14'h2AAA, 1'b1, 14'h1555, 1'b1, 1'b0}, // R2 gated, R3 flag
        {1'b0, 1'b1, 14'h0003, 1'b0, 14'h0003, 1'b0, 1'b0}, // R2 par ignored, R4
        {1'b0, 1'b1, 14'h0001, 1'b1, 14'h0001, 1'b0, 1'b1}, // R4 expire, R6 hold
        {1'b1, 1'b1, 14'h0000, 1'b0, 14'h0001, 1'b1, 1'b0}, // R3 new error
        {1'b0, 1'b1, 14'h0000, 1'b0, 14'h0000, 1'b1, 1'b0}, // R5 rehit
        {1'b0, 1'b1, 14'h0000, 1'b0, 14'h0000, 1'b1, 1'b0}, // R5 count restarted
        {1'b0, 1'b1, 14'h0000, 1'b0, 14'h0000, 1'b0, 1'b1}, // R5 expire late
        {1'b0, 1'b1, 14'h0000, 1'b0, 14'h0000, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic c0, input logic c1,
                        input logic [W-1:0] d, input logic p);
        sel0_n = c0;
        sel1_n = c1;
        addr_i = d;
        par_i  = p;
        @(posedge clk);
        #2;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        // R7: values under reset
        @(posedge clk);
        #2;
        chk("R7 addr_q", addr_q, '0);
        chk("R7 ppar_o", W'(ppar_o), '0);
        chk("R7 err_n", W'(err_n), W'(1));
        @(posedge clk);
        #2;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [32:0] v;
            v = VEC[i];
            step(v[32], v[31], v[30:17], v[16]);
            chk($sformatf("R1/R2 row %0d addr_q", i), addr_q, v[15:2]);
            chk($sformatf("R6 row %0d ppar_o", i), W'(v[1]), W'(ppar_o)) ;
            chk($sformatf("R3/R4/R5 row %0d err_n", i), W'(err_n), W'(v[0]));
        end

        // R7: asynchronous clear in the middle of a stretch
        step(1'b0, 1'b1, 14'h0101, 1'b0);
        step(1'b0, 1'b1, 14'h0000, 1'b1);   // 0101 xor 1 = 1: error
        step(1'b1, 1'b1, 14'h0000, 1'b0);
        chk("R3 err_n before reset", W'(err_n), '0);
        chk("R6 ppar_o before reset", W'(ppar_o), W'(1));
        rst_n = 1'b0;
        #1;
        chk("R7 async addr_q", addr_q, '0);
        chk("R7 async ppar_o", W'(ppar_o), '0);
        chk("R7 async err_n", W'(err_n), W'(1));
        @(posedge clk);
        #2;
        chk("R7 held err_n", W'(err_n), W'(1));

        // R8: release with quiet inputs
        sel0_n = 1'b0;
        sel1_n = 1'b1;
        addr_i = '0;
        par_i  = 1'b0;
        rst_n  = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b1, 14'h0000, 1'b0);
            chk($sformatf("R8 err_n cycle %0d", k), W'(err_n), W'(1));
            chk($sformatf("R8 ppar_o cycle %0d", k), W'(ppar_o), '0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule